// File: doc/BRIEF.md
# Periodic Measurement Sequencer with Conversion-Clock Divider

This block paces the sampling of an on-die temperature sensor. It derives a slow conversion tick from the fast bus clock through an 8-bit programmable divider. It then runs the measurement sequence in one of three modes: one-shot, back-to-back, or timed repeat. Every run first waits a programmable power-up delay. A conversion then lasts a base tick count scaled by the chosen resolution. At the end the sensor value is captured into an output register and a one-cycle ready pulse is raised.

Control comes from a go strobe, a halt strobe and a master enable. The mode, resolution, divider setting, repeat period and power-up count are level inputs that are held steady while a run is active. The analog converter is not part of the block. A plain data input stands in for its result, and the block samples that input on the edge that closes each conversion.

Top module: `thermo_meas_seq`

## Requirements
- R1: After reset, `busy`, `sample_rdy` and `sample_out` are all zero, and `sample_rdy` is only ever high in a cycle that follows a cycle where `busy` was high.
- R2: With `div_on` = 1, one conversion tick occurs every `div_val`+1 clocks. With `div_on` = 0, every clock is a tick.
- R3: After an accepted go, the sequencer spends `pwrup_ticks` ticks plus one clock in power-up before the first conversion. With no divider and delay P, this is P+1 clocks.
- R4: A conversion lasts `BASE_TICKS`·2^`res_sel` ticks. On the clock edge that closes the last tick, `sample_out` takes `sense_in`, and `sample_rdy` is high for the following cycle. `sample_out` changes at no other time. Without the divider, the ready pulse comes P+2+L clocks after the go edge.
- R5: Mode code 0, and also the unused code 3, performs one conversion and then returns to idle (`busy` = 0).
- R6: Mode code 1 starts the next conversion on the cycle right after one finishes, with no new power-up. Ready pulses are then L ticks apart.
- R7: Mode code 2 starts conversions `period_ticks` ticks apart, with the count taken from the start of each conversion. If the period has already run out when a conversion ends, the next one starts after a single gap cycle.
- R8: A `meas_halt` strobe returns the block to idle on the next edge from any state. It abandons a conversion in progress without updating `sample_out` or pulsing ready, and it overrides a go in the same cycle.
- R9: With `mon_en` = 0, the block is idle on the next edge, the divider phase is cleared, and go strobes are ignored.
- R10: A go strobe while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Master enable; low forces idle |
| meas_go | input | 1 | Start strobe, accepted only in idle |
| meas_halt | input | 1 | Stop strobe |
| meas_mode | input | 2 | 0 one-shot, 1 back-to-back, 2 timed, 3 as 0 |
| res_sel | input | RES_W | Resolution code; conversion length scales by 2^code |
| div_on | input | 1 | Divider enable |
| div_val | input | DIV_W | Divider value; tick rate is clk/(div_val+1) |
| period_ticks | input | PERIOD_W | Repeat period in ticks for timed mode |
| pwrup_ticks | input | PUD_W | Power-up delay in ticks |
| sense_in | input | DATA_W | Sensor result stand-in |
| sample_out | output | DATA_W | Last captured result |
| sample_rdy | output | 1 | One-cycle pulse when a new result is captured |
| busy | output | 1 | High whenever a run is active |

## Verification
The bench targets the exact clock of the ready pulse. An off-by-one in the power-up or conversion count would move the pulse by a cycle, and the bench computes that count from P+2+L. It checks ready-to-ready spacing in timed mode both when the period exceeds the conversion and when it is shorter. A design that measured the period from the end of a conversion would stretch the first case, and one that skipped the gap cycle would shorten the second. It halts mid-conversion and drops enable mid-run: a design that latched the sensor late or kept counting would show a changed result or a stray pulse. It also sends a go while a run is active, which a careless design would use to restart the power-up.

// File: rtl/tms_pkg.sv
package tms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PWRUP = 2'd1,
    ST_CONV  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_t;

  localparam logic [1:0] MODE_ONCE  = 2'd0;
  localparam logic [1:0] MODE_RUN   = 2'd1;
  localparam logic [1:0] MODE_TIMED = 2'd2;
endpackage

// File: rtl/tms_tick_div.sv
module tms_tick_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         div_on,
  input  logic [W-1:0] div_val,
  output logic         tick
);
  logic [W-1:0] phase;
  logic         wrap;

  assign wrap = (phase == div_val);

  always_ff @(posedge clk) begin
    if (rst || !run || !div_on) phase <= '0;
    else if (wrap)              phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  assign tick = run && (!div_on || wrap);
endmodule

// File: rtl/tms_step_cnt.sv
module tms_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/thermo_meas_seq.sv
module thermo_meas_seq
  import tms_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PERIOD_W   = 24,
  parameter int PUD_W      = 8,
  parameter int RES_W      = 2,
  parameter int DATA_W     = 16,
  parameter int BASE_TICKS = 2372
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mon_en,
  input  logic                meas_go,
  input  logic                meas_halt,
  input  logic [1:0]          meas_mode,
  input  logic [RES_W-1:0]    res_sel,
  input  logic                div_on,
  input  logic [DIV_W-1:0]    div_val,
  input  logic [PERIOD_W-1:0] period_ticks,
  input  logic [PUD_W-1:0]    pwrup_ticks,
  input  logic [DATA_W-1:0]   sense_in,
  output logic [DATA_W-1:0]   sample_out,
  output logic                sample_rdy,
  output logic                busy
);
  localparam int RES_STEPS = 1 << RES_W;
  localparam int CONV_MAX  = BASE_TICKS * (1 << (RES_STEPS - 1));
  localparam int CONV_W    = $clog2(CONV_MAX + 1);

  seq_state_t state, state_nxt;
  logic tick, go_on;
  logic [PUD_W-1:0]    pud_cnt;
  logic [CONV_W-1:0]   conv_cnt, conv_len;
  logic [PERIOD_W-1:0] per_cnt;
  logic pud_done, conv_last, conv_fin, per_due, start_conv;
  logic in_conv, in_gap, in_pwrup;

  assign go_on    = mon_en && !meas_halt;
  assign in_conv  = (state == ST_CONV);
  assign in_gap   = (state == ST_GAP);
  assign in_pwrup = (state == ST_PWRUP);

  tms_tick_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(mon_en), .div_on(div_on),
    .div_val(div_val), .tick(tick)
  );

  // power-up delay counter
  tms_step_cnt #(.W(PUD_W)) u_pud (
    .clk(clk), .rst(rst), .clr(!go_on || !in_pwrup),
    .inc(tick && !pud_done), .cnt(pud_cnt)
  );

  // conversion length counter
  tms_step_cnt #(.W(CONV_W)) u_conv (
    .clk(clk), .rst(rst), .clr(!go_on || !in_conv || conv_last),
    .inc(in_conv && tick), .cnt(conv_cnt)
  );

  // ticks since the current conversion began
  tms_step_cnt #(.W(PERIOD_W)) u_per (
    .clk(clk), .rst(rst),
    .clr(!go_on || start_conv || !(in_conv || in_gap)),
    .inc(tick && (in_conv || in_gap)), .cnt(per_cnt)
  );

  assign conv_len  = CONV_W'(BASE_TICKS) << res_sel;
  assign pud_done  = (pud_cnt == pwrup_ticks);
  assign conv_last = tick && (conv_cnt == conv_len - 1'b1);
  assign conv_fin  = in_conv && conv_last;
  assign per_due   = tick &&
                     (({1'b0, per_cnt} + (PERIOD_W+1)'(1)) >= {1'b0, period_ticks});
  assign start_conv = (in_pwrup && pud_done) ||
                      (in_gap && per_due) ||
                      (conv_fin && meas_mode == MODE_RUN);

  always_comb begin
    state_nxt = state;
    if (!go_on) begin
      state_nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (meas_go) state_nxt = ST_PWRUP;
        ST_PWRUP: if (pud_done) state_nxt = ST_CONV;
        ST_CONV: begin
          if (conv_fin) begin
            if (meas_mode == MODE_RUN)        state_nxt = ST_CONV;
            else if (meas_mode == MODE_TIMED) state_nxt = ST_GAP;
            else                              state_nxt = ST_IDLE;
          end
        end
        ST_GAP:   if (per_due) state_nxt = ST_CONV;
        default:  state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      sample_out <= '0;
      sample_rdy <= 1'b0;
    end else begin
      state      <= state_nxt;
      busy       <= (state_nxt != ST_IDLE);
      sample_rdy <= go_on && conv_fin;
      if (go_on && conv_fin) sample_out <= sense_in;
    end
  end
endmodule

// File: rtl/tms_checker.sv
module tms_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mon_en,
  input logic              meas_halt,
  input logic [1:0]        meas_mode,
  input logic [DATA_W-1:0] sample_out,
  input logic              sample_rdy,
  input logic              busy
);
  a_r1_rdy_after_busy: assert property (@(posedge clk) disable iff (rst)
    sample_rdy |-> $past(busy));

  a_r4_hold_result: assert property (@(posedge clk) disable iff (rst)
    !sample_rdy |-> $stable(sample_out));

  a_r5_once_returns_idle: assert property (@(posedge clk) disable iff (rst)
    (sample_rdy && ($past(meas_mode) == 2'd0)) |-> !busy);

  a_r6_run_stays_busy: assert property (@(posedge clk) disable iff (rst)
    (sample_rdy && ($past(meas_mode) == 2'd1)) |-> busy);

  a_r8_halt_goes_idle: assert property (@(posedge clk) disable iff (rst)
    $past(meas_halt) |-> (!busy && !sample_rdy));

  a_r9_off_goes_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(mon_en) |-> (!busy && !sample_rdy));
endmodule

bind thermo_meas_seq tms_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .meas_halt(meas_halt),
  .meas_mode(meas_mode), .sample_out(sample_out),
  .sample_rdy(sample_rdy), .busy(busy)
);

// File: tb/sim_thermo_meas_seq.sv
`timescale 1ns/1ps
module sim_thermo_meas_seq;
  localparam int BASE = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mon_en = 1'b0, meas_go = 1'b0, meas_halt = 1'b0, div_on = 1'b0;
  logic [1:0]  meas_mode = 2'd0, res_sel = 2'd0;
  logic [7:0]  div_val = 8'd0, pwrup_ticks = 8'd0;
  logic [23:0] period_ticks = 24'd0;
  logic [15:0] sense_in = 16'h0;
  logic [15:0] sample_out;
  logic        sample_rdy, busy;

  int checks = 0, failures = 0, cyc = 0, rdy_count = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_st = 0, m_dc = 0, m_pc = 0, m_cc = 0, m_per = 0;
  int m_data = 0, m_rdy = 0, tk = 0;

  always #2.5 clk = ~clk;

  thermo_meas_seq #(.BASE_TICKS(BASE)) u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .meas_go(meas_go),
    .meas_halt(meas_halt), .meas_mode(meas_mode), .res_sel(res_sel),
    .div_on(div_on), .div_val(div_val), .period_ticks(period_ticks),
    .pwrup_ticks(pwrup_ticks), .sense_in(sense_in),
    .sample_out(sample_out), .sample_rdy(sample_rdy), .busy(busy)
  );

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_st = 0; m_dc = 0; m_pc = 0; m_cc = 0; m_per = 0; m_data = 0; m_rdy = 0;
    end else begin
      tk = (!div_on || m_dc == int'(div_val)) ? 1 : 0;
      if (!mon_en || !div_on) m_dc = 0;
      else if (m_dc == int'(div_val)) m_dc = 0;
      else m_dc = m_dc + 1;
      m_rdy = 0;
      if (!mon_en || meas_halt) m_st = 0;
      else begin
        case (m_st)
          0: if (meas_go) begin m_st = 1; m_pc = 0; end
          1: begin
            if (m_pc == int'(pwrup_ticks)) begin m_st = 2; m_cc = 0; m_per = 0; end
            else if (tk == 1) m_pc = m_pc + 1;
          end
          2: if (tk == 1) begin
            m_per = m_per + 1;
            if (m_cc == (BASE << res_sel) - 1) begin
              m_data = int'(sense_in); m_rdy = 1; m_cc = 0;
              if (meas_mode == 2'd1) m_per = 0;
              else if (meas_mode == 2'd2) m_st = 3;
              else m_st = 0;
            end else m_cc = m_cc + 1;
          end
          default: if (tk == 1) begin
            if (m_per + 1 >= int'(period_ticks)) begin m_st = 2; m_cc = 0; m_per = 0; end
            else m_per = m_per + 1;
          end
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model, sampled on the falling edge
  always @(negedge clk) begin
    sense_in <= sense_in + 16'h0101;
    if (sample_rdy) rdy_count++;
    if (!rst && !done) begin
      chk(cur_req, "busy", int'(busy), (m_st != 0) ? 1 : 0);
      chk(cur_req, "sample_rdy", int'(sample_rdy), m_rdy);
      chk(cur_req, "sample_out", int'(sample_out), m_data);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_go();
    @(negedge clk); meas_go = 1'b1;
    @(negedge clk); meas_go = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); meas_halt = 1'b1;
    @(negedge clk); meas_halt = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!sample_rdy && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, r0;
    logic [15:0] held;
    idle(3);
    // R1 reset values
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset rdy", int'(sample_rdy), 0);
    chk("R1", "reset data", int'(sample_out), 0);
    @(negedge clk); rst = 1'b0; mon_en = 1'b1;
    idle(2);

    // R3 R4 one-shot latency without divider: P+2+L
    cur_req = "R3"; meas_mode = 2'd0; res_sel = 2'd1; pwrup_ticks = 8'd5;
    pulse_go(); n = 1;
    while (!sample_rdy && n < 500) begin @(negedge clk); n++; end
    chk("R4", "ready latency", n, 5 + 2 + (BASE << 1));
    @(negedge clk);
    chk("R5", "idle after one-shot", int'(busy), 0);

    // R10 go while busy does not restart
    cur_req = "R10"; pulse_go(); n = 1;
    idle(4); meas_go = 1'b1; @(negedge clk); meas_go = 1'b0; n = n + 5;
    while (!sample_rdy && n < 500) begin @(negedge clk); n++; end
    chk("R10", "latency with extra go", n, 5 + 2 + (BASE << 1));
    idle(3);

    // R2 divided tick, one-shot; model compares each clock
    cur_req = "R2"; div_on = 1'b1; div_val = 8'd3; res_sel = 2'd0; pwrup_ticks = 8'd2;
    pulse_go(); wait_rdy(n);
    chk("R2", "divided run completes", int'(sample_rdy), 1);
    idle(4);

    // R5 code 3 behaves as one-shot
    cur_req = "R5"; div_on = 1'b0; meas_mode = 2'd3; pwrup_ticks = 8'd1;
    pulse_go(); wait_rdy(n); @(negedge clk);
    chk("R5", "code 3 idle", int'(busy), 0);
    idle(3);

    // R6 back-to-back with divider of 2
    cur_req = "R6"; meas_mode = 2'd1; div_on = 1'b1; div_val = 8'd1; res_sel = 2'd2;
    pwrup_ticks = 8'd0;
    pulse_go(); wait_rdy(n); @(negedge clk); wait_rdy(n);
    chk("R6", "back-to-back spacing", n + 1, 2 * (BASE << 2));
    r0 = rdy_count; idle(4 * 2 * (BASE << 2));
    chk("R6", "pulses in window", rdy_count - r0, 4);
    cur_req = "R8"; pulse_halt(); idle(3);
    chk("R8", "halt idles", int'(busy), 0);

    // R7 timed mode, period longer than conversion
    cur_req = "R7"; div_on = 1'b0; meas_mode = 2'd2; res_sel = 2'd0; period_ticks = 24'd20;
    pulse_go(); wait_rdy(n); @(negedge clk); wait_rdy(n);
    chk("R7", "period spacing", n + 1, 20);
    @(negedge clk); wait_rdy(n);
    chk("R7", "period spacing again", n + 1, 20);
    pulse_halt(); idle(3);

    // R7 timed mode, period shorter than conversion: one gap cycle
    period_ticks = 24'd2; res_sel = 2'd1;
    pulse_go(); wait_rdy(n); @(negedge clk); wait_rdy(n);
    chk("R7", "short period spacing", n + 1, (BASE << 1) + 1);
    pulse_halt(); idle(3);

    // R8 halt mid conversion, halt beats go
    cur_req = "R8"; meas_mode = 2'd0; res_sel = 2'd2; pwrup_ticks = 8'd0;
    held = sample_out; r0 = rdy_count;
    pulse_go(); idle(6); pulse_halt(); idle(20);
    chk("R8", "data kept after halt", int'(sample_out), int'(held));
    chk("R8", "no pulse after halt", rdy_count - r0, 0);
    @(negedge clk); meas_go = 1'b1; meas_halt = 1'b1;
    @(negedge clk); meas_go = 1'b0; meas_halt = 1'b0;
    chk("R8", "halt overrides go", int'(busy), 0);

    // R9 enable drop mid run, go ignored while off
    cur_req = "R9"; meas_mode = 2'd1; res_sel = 2'd0;
    pulse_go(); idle(5);
    @(negedge clk); mon_en = 1'b0; held = sample_out; r0 = rdy_count;
    pulse_go(); idle(10);
    chk("R9", "off busy", int'(busy), 0);
    chk("R9", "off data kept", int'(sample_out), int'(held));
    chk("R9", "off no pulse", rdy_count - r0, 0);
    mon_en = 1'b1; idle(3);
    chk("R9", "go while off ignored", int'(busy), 0);

    finish_run();
  end
endmodule